// File: doc/BRIEF.md
# CSR Read-Modify-Write Access Sequencer

This unit carries out the three control-register instructions of a core: swap, set bits and clear bits. For each instruction it is given the operation, the 12-bit register address, the source operand, a flag that tells whether the source register field was nonzero, the current privilege level and the two counter-enable words. It does not store the registers. It reads the old contents through the read side of an external register-file port and checks that the access is allowed. When a write is due, it drives the new value back through the write side of the same port.

The legality checks use only the address bits. A group of performance-counter and event-selector addresses is answered with zero by the unit itself, and the user-level counters among them are gated by a counter-enable bit. The outcome is registered. One cycle after the request the unit raises a done strobe, together with either the pre-write value or an illegal-instruction flag.

Top module: `csr_access_unit`

## Requirements
- R1: If the current privilege `curPriv` (0 user, 1 supervisor, 2 reserved, 3 machine) is numerically below address bits [9:8], the access is illegal.
- R2: An address with bits [11:10] equal to 2'b11 is read-only. An access that carries write intent to it is illegal, and an access without write intent to it is allowed.
- R3: Write intent is decided as follows. Operation code 2'b01 (swap) and code 2'b00 (also treated as swap) always carry it. Code 2'b10 (set) and code 2'b11 (clear) carry it only when `srcNonZero` is high. Without write intent no write reaches the register file.
- R4: A swap writes the source value. A set writes old OR source. A clear writes old AND NOT source. The result returned is always the contents before the write.
- R5: The counter-enable word is `sCntEn` in user mode, `mCntEn` in supervisor mode, and all ones at any higher level. The bit consulted is the one indexed by address bits [4:0].
- R6: User performance counters occupy 0xC03–0xC1F and 0xC83–0xC9F. When the enable bit is set they return zero without using the register file. When the bit is clear the access goes to the register file like any other address.
- R7: Machine performance counters occupy 0xB03–0xB1F and 0xB83–0xB9F, and event selectors occupy 0x323–0x33F. All of them return zero at any allowed privilege. A write to any of them is dropped and is not illegal.
- R8: An address that the register file does not acknowledge (`rfRdHit` low) is illegal, unless R6 or R7 answers it.
- R9: An illegal access issues no write, raises `illegalFlag` together with the done strobe, and returns zero data.
- R10: A write is presented on the port during the request cycle. `doneStb` is high for exactly the cycle after each request cycle, and `resultData` and `illegalFlag` are valid in that same cycle.
- R11: After reset `doneStb`, `illegalFlag` and `resultData` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Instruction present this cycle |
| reqOp | input | 2 | Operation code (00/01 swap, 10 set, 11 clear) |
| reqAddr | input | 12 | Register address |
| reqSrc | input | XLEN | Source operand |
| srcNonZero | input | 1 | Source register field is nonzero |
| curPriv | input | 2 | Current privilege level |
| sCntEn | input | 32 | Supervisor counter-enable word |
| mCntEn | input | 32 | Machine counter-enable word |
| rfAddr | output | 12 | Register-file address for read and write |
| rfRdData | input | XLEN | Register-file read data |
| rfRdHit | input | 1 | Register file holds the addressed register |
| rfWrEn | output | 1 | Register-file write strobe |
| rfWrData | output | XLEN | Register-file write data |
| doneStb | output | 1 | Result valid, one cycle after request |
| resultData | output | XLEN | Pre-write register value |
| illegalFlag | output | 1 | Illegal-instruction result |

## Verification
The bench builds the unit with XLEN set to 8. With that width the data arithmetic stays small, so every one of the 4096 addresses can be swept at all four privilege levels, with the operation, the source and the nonzero flag rotating. That sweep reaches every privilege, read-only, counter-window and unacknowledged-address case. A separate sweep walks each counter index through set and clear enable bits at every privilege. The register file is a small behavioural memory that acknowledges every address whose low nibble is not 0xF.

// File: rtl/csr_acc_pkg.sv
package csr_acc_pkg;
  localparam int ADDR_W   = 12;
  localparam int CNT_EN_W = 32;
  localparam int IDX_W    = $clog2(CNT_EN_W);

  typedef enum logic [1:0] {
    OP_SWAP_ALT = 2'b00,
    OP_SWAP     = 2'b01,
    OP_SET      = 2'b10,
    OP_CLR      = 2'b11
  } csrOpE;

  // control-to-datapath strobes
  typedef struct packed {
    logic fire;
    logic zeroRead;
    logic issueWrite;
    logic illegal;
  } accStrobeT;
endpackage

// File: rtl/csr_acc_ctrl.sv
module csr_acc_ctrl
  import csr_acc_pkg::*;
(
  input  logic                reqValid,
  input  logic [1:0]          reqOp,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                srcNonZero,
  input  logic [1:0]          curPriv,
  input  logic [CNT_EN_W-1:0] sCntEn,
  input  logic [CNT_EN_W-1:0] mCntEn,
  input  logic                rfRdHit,
  output accStrobeT           strobes
);
  logic               wantWrite;
  logic               privFail;
  logic               roFail;
  logic [IDX_W-1:0]   cntIdx;
  logic               inCntWindow;
  logic               userHpm;
  logic               machHpm;
  logic               evtSel;
  logic [CNT_EN_W-1:0] enWord;
  logic               zeroRead;
  logic               illegal;

  // swap codes always write; set/clear only with a nonzero source field
  assign wantWrite = (reqOp[1] == 1'b0) ? 1'b1 : srcNonZero;

  assign privFail = curPriv < reqAddr[9:8];
  assign roFail   = wantWrite && (reqAddr[11:10] == 2'b11);

  assign cntIdx      = reqAddr[IDX_W-1:0];
  assign inCntWindow = (reqAddr[6:5] == 2'b00) && (cntIdx >= IDX_W'(3));
  assign userHpm     = (reqAddr[11:8] == 4'hC) && inCntWindow;
  assign machHpm     = (reqAddr[11:8] == 4'hB) && inCntWindow;
  assign evtSel      = (reqAddr[11:5] == 7'b0011001) && (cntIdx >= IDX_W'(3));

  always_comb begin
    case (curPriv)
      2'd0:    enWord = sCntEn;
      2'd1:    enWord = mCntEn;
      default: enWord = '1;
    endcase
  end

  assign zeroRead = (userHpm && enWord[cntIdx]) || machHpm || evtSel;
  assign illegal  = privFail || roFail || (!zeroRead && !rfRdHit);

  always_comb begin
    strobes.fire       = reqValid;
    strobes.zeroRead   = zeroRead;
    strobes.illegal    = illegal;
    strobes.issueWrite = reqValid && wantWrite && !illegal && !zeroRead;
  end
endmodule

// File: rtl/csr_acc_dp.sv
module csr_acc_dp
  import csr_acc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  accStrobeT       strobes,
  input  logic [1:0]      reqOp,
  input  logic [XLEN-1:0] reqSrc,
  input  logic [XLEN-1:0] rfRdData,
  output logic            rfWrEn,
  output logic [XLEN-1:0] rfWrData,
  output logic            doneStb,
  output logic [XLEN-1:0] resultData,
  output logic            illegalFlag
);
  logic [XLEN-1:0] oldVal;
  logic [XLEN-1:0] newVal;

  assign oldVal = strobes.zeroRead ? '0 : rfRdData;

  always_comb begin
    case (csrOpE'(reqOp))
      OP_SET:  newVal = oldVal | reqSrc;
      OP_CLR:  newVal = oldVal & ~reqSrc;
      default: newVal = reqSrc;
    endcase
  end

  assign rfWrEn   = strobes.issueWrite;
  assign rfWrData = newVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneStb     <= 1'b0;
      illegalFlag <= 1'b0;
      resultData  <= '0;
    end else begin
      doneStb     <= strobes.fire;
      illegalFlag <= strobes.fire && strobes.illegal;
      resultData  <= (strobes.fire && !strobes.illegal) ? oldVal : '0;
    end
  end
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csr_acc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqOp,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [XLEN-1:0]     reqSrc,
  input  logic                srcNonZero,
  input  logic [1:0]          curPriv,
  input  logic [CNT_EN_W-1:0] sCntEn,
  input  logic [CNT_EN_W-1:0] mCntEn,
  output logic [ADDR_W-1:0]   rfAddr,
  input  logic [XLEN-1:0]     rfRdData,
  input  logic                rfRdHit,
  output logic                rfWrEn,
  output logic [XLEN-1:0]     rfWrData,
  output logic                doneStb,
  output logic [XLEN-1:0]     resultData,
  output logic                illegalFlag
);
  accStrobeT strobes;

  assign rfAddr = reqAddr;

  csr_acc_ctrl u_ctrl (
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .reqAddr   (reqAddr),
    .srcNonZero(srcNonZero),
    .curPriv   (curPriv),
    .sCntEn    (sCntEn),
    .mCntEn    (mCntEn),
    .rfRdHit   (rfRdHit),
    .strobes   (strobes)
  );

  csr_acc_dp #(.XLEN(XLEN)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqOp      (reqOp),
    .reqSrc     (reqSrc),
    .rfRdData   (rfRdData),
    .rfWrEn     (rfWrEn),
    .rfWrData   (rfWrData),
    .doneStb    (doneStb),
    .resultData (resultData),
    .illegalFlag(illegalFlag)
  );
endmodule

// File: rtl/csr_access_unit_chk.sv
module csr_access_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [1:0]      reqOp,
  input logic [11:0]     reqAddr,
  input logic            srcNonZero,
  input logic [1:0]      curPriv,
  input logic            rfWrEn,
  input logic            doneStb,
  input logic [XLEN-1:0] resultData,
  input logic            illegalFlag
);
  // R1
  priv_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (curPriv < reqAddr[9:8])) |=> illegalFlag);

  // R9
  no_write_when_barred_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> ((curPriv >= reqAddr[9:8]) && (reqAddr[11:10] != 2'b11)));

  // R3
  read_only_intent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp[1] && !srcNonZero) |-> !rfWrEn);

  // R10
  done_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> doneStb);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !doneStb);

  // R10
  write_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> reqValid);

  // R9
  illegal_data_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneStb && illegalFlag) |-> (resultData == '0));

  // R7
  mach_counter_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[11:8] == 4'hB && reqAddr[6:5] == 2'b00 && reqAddr[4:0] >= 5'd3)
      |-> !rfWrEn);

  // R7
  mach_counter_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && curPriv == 2'b11 && reqAddr[11:8] == 4'hB && reqAddr[6:5] == 2'b00
      && reqAddr[4:0] >= 5'd3) |=> (!illegalFlag && resultData == '0));
endmodule

bind csr_access_unit csr_access_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqOp      (reqOp),
  .reqAddr    (reqAddr),
  .srcNonZero (srcNonZero),
  .curPriv    (curPriv),
  .rfWrEn     (rfWrEn),
  .doneStb    (doneStb),
  .resultData (resultData),
  .illegalFlag(illegalFlag)
);

// File: tb/csr_access_unit_tb.sv
`timescale 1ns/1ps
module csr_access_unit_tb;
  localparam int XLEN = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic [1:0]      reqOp = 2'b00;
  logic [11:0]     reqAddr = '0;
  logic [XLEN-1:0] reqSrc = '0;
  logic            srcNonZero = 1'b0;
  logic [1:0]      curPriv = 2'b11;
  logic [31:0]     sCntEn = 32'hA5A5_5A5A;
  logic [31:0]     mCntEn = 32'h0F0F_F0F0;
  logic [11:0]     rfAddr;
  logic [XLEN-1:0] rfRdData;
  logic            rfRdHit;
  logic            rfWrEn;
  logic [XLEN-1:0] rfWrData;
  logic            doneStb;
  logic [XLEN-1:0] resultData;
  logic            illegalFlag;

  int checkCnt = 0;
  int failCnt  = 0;

  logic [XLEN-1:0] mem [64];

  always #2 clk = ~clk;

  assign rfRdData = mem[rfAddr[5:0]];
  assign rfRdHit  = (rfAddr[3:0] != 4'hF);

  always @(posedge clk) if (rfWrEn) mem[rfAddr[5:0]] <= rfWrData;

  csr_access_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqSrc(reqSrc), .srcNonZero(srcNonZero), .curPriv(curPriv), .sCntEn(sCntEn),
    .mCntEn(mCntEn), .rfAddr(rfAddr), .rfRdData(rfRdData), .rfRdHit(rfRdHit),
    .rfWrEn(rfWrEn), .rfWrData(rfWrData), .doneStb(doneStb), .resultData(resultData),
    .illegalFlag(illegalFlag)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic doAccess(input logic [1:0] op, input logic [11:0] a,
                          input logic [XLEN-1:0] src, input logic nz, input logic [1:0] pv);
    int lo;
    bit userHpm, machZero, served, hit, privBad, roBad, intent, enBit, expIll, expWr;
    logic [31:0] en;
    logic [XLEN-1:0] prev, old, nv, expRes, expMem;
    string tag;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqSrc = src; srcNonZero = nz; curPriv = pv;
    lo = int'(a) % 32;
    userHpm  = (a >= 12'hC03 && a <= 12'hC1F) || (a >= 12'hC83 && a <= 12'hC9F);
    machZero = (a >= 12'hB03 && a <= 12'hB1F) || (a >= 12'hB83 && a <= 12'hB9F)
               || (a >= 12'h323 && a <= 12'h33F);
    en = (pv == 2'd0) ? sCntEn : (pv == 2'd1) ? mCntEn : 32'hFFFF_FFFF;
    enBit  = en[lo];
    served = machZero || (userHpm && enBit);
    hit    = (int'(a) % 16) != 15;
    privBad = int'(pv) < (int'(a) / 256) % 4;
    intent  = (op == 2'b00 || op == 2'b01) || nz;
    roBad   = intent && (int'(a) / 1024 == 3);
    expIll  = privBad || roBad || (!served && !hit);
    prev = mem[a[5:0]];
    old  = served ? '0 : prev;
    if (op == 2'b10) nv = old | src;
    else if (op == 2'b11) nv = old & ~src;
    else nv = src;
    expWr  = !expIll && intent && !served;
    expRes = expIll ? '0 : old;
    expMem = expWr ? nv : prev;
    if (privBad) tag = "R1";
    else if (roBad) tag = "R2";
    else if (machZero) tag = "R7";
    else if (userHpm) tag = "R6";
    else if (!hit) tag = "R8";
    else tag = "R4";
    @(negedge clk);
    reqValid = 1'b0;
    // R10: done strobe one cycle after the request
    check("R10", "done strobe", 32'(doneStb), 32'd1);
    check(tag, "illegal flag", 32'(illegalFlag), 32'(expIll));
    check(expIll ? "R9" : tag, "result data", 32'(resultData), 32'(expRes));
    // R3: write happens only with intent and a legal access
    check("R3", "register contents", 32'(mem[a[5:0]]), 32'(expMem));
    @(negedge clk);
    check("R10", "done single cycle", 32'(doneStb), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    // R11: reset values
    check("R11", "done after reset", 32'(doneStb), 32'd0);
    check("R11", "illegal after reset", 32'(illegalFlag), 32'd0);
    check("R11", "data after reset", 32'(resultData), 32'd0);
    rstN = 1'b1;

    // directed corner cases
    doAccess(2'b10, 12'h300, 8'h00, 1'b0, 2'd3); // R4 plain read
    doAccess(2'b10, 12'hF11, 8'hFF, 1'b0, 2'd3); // R2 read-only, read only: legal
    doAccess(2'b01, 12'hF11, 8'hFF, 1'b1, 2'd3); // R2 read-only, swap: illegal
    doAccess(2'b11, 12'h305, 8'h0F, 1'b1, 2'd3); // R4 clear
    doAccess(2'b00, 12'h305, 8'h3C, 1'b0, 2'd3); // R3 code 00 swaps
    doAccess(2'b10, 12'h305, 8'hC0, 1'b1, 2'd1); // R1 supervisor to machine

    // exhaustive address x privilege sweep
    for (int a = 0; a < 4096; a++) begin
      for (int p = 0; p < 4; p++) begin
        doAccess(2'((a + p) % 4), 12'(a), 8'((a * 7) ^ (p * 8'h55)),
                 1'(((a >> 2) ^ p) & 1), 2'(p));
      end
    end

    // R5: counter-enable word selection and bit index
    for (int p = 0; p < 4; p++) begin
      for (int idx = 3; idx < 32; idx++) begin
        sCntEn = 32'd1 << idx; mCntEn = 32'd0;
        doAccess(2'b10, 12'hC00 | 12'(idx), 8'h00, 1'b0, 2'(p));
        sCntEn = 32'd0; mCntEn = 32'd1 << idx;
        doAccess(2'b11, 12'hC80 | 12'(idx), 8'h00, 1'b0, 2'(p));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    #(4 * 190000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule